// File: doc/BRIEF.md
# Address-Strobed I2C Pin Latch

This block is a two-wire serial port hidden inside a read-only memory window. The host never writes data to it. Instead, a read cycle that lands in the port's small address window carries the new line levels in the two lowest address bits. Software bit-bangs the clock and data lines by reading from one of four aliased locations. The same read returns the sensed line levels on the low data bits. This lets a ROM socket, which only sees reads, control two pull-up bus lines.

The host's strobe, address and coarse select are registered before use. A qualified access updates the line latches one clock later. The data line is open-drain: its output value is always low, and the latch only switches its output enable. Both pad inputs pass through a synchronizer before they are returned on the data bus. Parameters set the address and data widths, the synchronizer depth, whether the clock line is push-pull or open-drain, and whether the port compares the full upper address itself or relies on the coarse select.

Top module: `i2c_addr_strobe_port`

## Requirements
- R1: An access is qualified only when, at one clock edge, `rom_oe_hi`=1, `coarse_sel`=1, `bus_addr[14]`=0, `bus_addr[5]`=0 and `bus_addr[4]`=1. With the default partial match, no other address bit takes part; 0xBFDC to 0xBFDF all qualify.
- R2: A qualified access loads the clock latch from `bus_addr[0]` and the data latch from `bus_addr[1]`. For both latches, 1 means released/high and 0 means pulled low.
- R3: When the strobe is low, the select is low, or the address misses, both latches keep their value.
- R4: `sda_out` is always 0. `sda_oe` equals the inverse of the data latch, so the data line is only ever pulled low or left floating.
- R5: With the default push-pull clock, `scl_oe`=1 and `scl_out` equals the clock latch.
- R6: In the cycle after a qualified access is registered, `dout_oe[0]`=1 and `dout[0]` carries the sensed data pin level, as it was before that access's update. In all other cycles `dout_oe[0]`=0.
- R7: `dout_oe[1]` follows `dout_oe[0]`, and `dout[1]` carries the sensed clock pin level. The enables of bits 2 and up are always 0.
- R8: The inputs are sampled at edge k. The latch outputs change after edge k+1 and not before.
- R9: While `rst_n`=0, and right after it, the clock latch is 1, `sda_oe`=0 and every bit of `dout_oe` is 0.
- R10: A strobe held over several cycles at one address leaves the same latch values as a single access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host address bus |
| rom_oe_hi | input | 1 | ROM output-enable strobe, active high |
| coarse_sel | input | 1 | Coarse window decode from the host |
| scl_in | input | 1 | Sensed clock pad level |
| sda_in | input | 1 | Sensed data pad level |
| scl_out | output | 1 | Clock pad output value |
| scl_oe | output | 1 | Clock pad output enable |
| sda_out | output | 1 | Data pad output value (always low) |
| sda_oe | output | 1 | Data pad output enable |
| dout | output | DATA_W | Read data to the host |
| dout_oe | output | DATA_W | Per-bit drive enable for `dout` |

## Verification
The bench emulates the wired-AND bus with pull-ups. It walks addresses that miss on exactly one of bits 14, 5 and 4, a dropped strobe, and a dropped select. A design that decoded the wrong bit would move a line on those reads. It also checks aliased hits outside 0xBFDC to 0xBFDF. A design that swapped the two address bits, or drove the data value instead of its enable, would show a line at the wrong level. An external device holding a released line low must appear on the readback. A design that echoed its latch instead of the pin would miss it. Directed tests cover the one-cycle update latency, a held strobe, and reset during an active transfer.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;
   // address bits whose positions are fixed by the host software
   localparam int SCL_SEL_BIT  = 0;
   localparam int SDA_SEL_BIT  = 1;
   localparam int BLOCK_LO_BIT = 14;
   localparam int ZERO_BIT     = 5;
   localparam int ONE_BIT      = 4;
   localparam int SEL_LSB      = 2;

   // read-data bit lanes carrying sensed pins
   localparam int RD_SDA_LANE  = 0;
   localparam int RD_SCL_LANE  = 1;

   typedef struct packed {
      logic hit;
      logic scl_lvl;
      logic sda_lvl;
   } port_cmd_t;
endpackage

// File: rtl/i2cps_strobe_reg.sv
module i2cps_strobe_reg
   import i2cps_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter bit          FULL_MATCH = 1'b0,
   parameter logic [31:0] BASE_ADDR  = 32'h0000_BFDC
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strobe,
   input  logic              sel,
   output port_cmd_t         cmd
);
   localparam int UPPER_W = ADDR_W - SEL_LSB;

   logic [ADDR_W-1:0] addr_q;
   logic              strobe_q;
   logic              sel_q;
   logic              upper_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         strobe_q <= 1'b0;
         sel_q    <= 1'b0;
      end else begin
         addr_q   <= addr;
         strobe_q <= strobe;
         sel_q    <= sel;
      end
   end

   generate
      if (FULL_MATCH) begin : g_full
         logic [UPPER_W-1:0] base_up;
         assign base_up  = BASE_ADDR[ADDR_W-1:SEL_LSB];
         assign upper_ok = (addr_q[ADDR_W-1:SEL_LSB] == base_up);
      end else begin : g_partial
         assign upper_ok = !addr_q[BLOCK_LO_BIT] && !addr_q[ZERO_BIT]
                           && addr_q[ONE_BIT];
      end
   endgenerate

   always_comb begin
      cmd.hit     = strobe_q && sel_q && upper_ok;
      cmd.scl_lvl = addr_q[SCL_SEL_BIT];
      cmd.sda_lvl = addr_q[SDA_SEL_BIT];
   end
endmodule

// File: rtl/i2cps_line_latch.sv
module i2cps_line_latch #(
   parameter bit RESET_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_VAL;
      else if (load) q <= d;
   end
endmodule

// File: rtl/i2cps_pin_sync.sv
module i2cps_pin_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl = pin;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], pin};
         end
         assign lvl = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cps_readback.sv
module i2cps_readback
   import i2cps_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              active,
   input  logic              sda_lvl,
   input  logic              scl_lvl,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] dout_oe
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      if (b == RD_SDA_LANE) begin : g_sda
         assign dout[b]    = sda_lvl;
         assign dout_oe[b] = active;
      end else if (b == RD_SCL_LANE) begin : g_scl
         assign dout[b]    = scl_lvl;
         assign dout_oe[b] = active;
      end else begin : g_idle
         assign dout[b]    = 1'b0;
         assign dout_oe[b] = 1'b0;
      end
   end
endmodule

// File: rtl/i2c_addr_strobe_port.sv
module i2c_addr_strobe_port
   import i2cps_pkg::*;
#(
   parameter int          ADDR_W         = 16,
   parameter int          DATA_W         = 8,
   parameter int          SYNC_STAGES    = 2,
   parameter bit          SCL_OPEN_DRAIN = 1'b0,
   parameter bit          FULL_MATCH     = 1'b0,
   parameter logic [31:0] BASE_ADDR      = 32'h0000_BFDC
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              rom_oe_hi,
   input  logic              coarse_sel,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_out,
   output logic              scl_oe,
   output logic              sda_out,
   output logic              sda_oe,
   output logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] dout_oe
);
   generate
      if (ADDR_W <= BLOCK_LO_BIT) begin : g_bad_addr
         $error("ADDR_W must cover the block-select bit");
      end
      if (ADDR_W > 32) begin : g_bad_addr_hi
         $error("ADDR_W above 32 is not supported");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold both readback lanes");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   port_cmd_t cmd;
   logic      scl_lat;
   logic      sda_lat;
   logic      scl_sensed;
   logic      sda_sensed;

   i2cps_strobe_reg #(
      .ADDR_W     (ADDR_W),
      .FULL_MATCH (FULL_MATCH),
      .BASE_ADDR  (BASE_ADDR)
   ) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .strobe (rom_oe_hi),
      .sel    (coarse_sel),
      .cmd    (cmd)
   );

   i2cps_line_latch #(.RESET_VAL(1'b1)) u_scl_lat (
      .clk (clk), .rst_n (rst_n), .load (cmd.hit), .d (cmd.scl_lvl), .q (scl_lat)
   );

   i2cps_line_latch #(.RESET_VAL(1'b1)) u_sda_lat (
      .clk (clk), .rst_n (rst_n), .load (cmd.hit), .d (cmd.sda_lvl), .q (sda_lat)
   );

   i2cps_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk (clk), .rst_n (rst_n), .pin (scl_in), .lvl (scl_sensed)
   );

   i2cps_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk (clk), .rst_n (rst_n), .pin (sda_in), .lvl (sda_sensed)
   );

   generate
      if (SCL_OPEN_DRAIN) begin : g_scl_od
         assign scl_out = 1'b0;
         assign scl_oe  = !scl_lat;
      end else begin : g_scl_pp
         assign scl_out = scl_lat;
         assign scl_oe  = 1'b1;
      end
   endgenerate

   assign sda_out = 1'b0;
   assign sda_oe  = !sda_lat;

   i2cps_readback #(.DATA_W(DATA_W)) u_rd (
      .active  (cmd.hit),
      .sda_lvl (sda_sensed),
      .scl_lvl (scl_sensed),
      .dout    (dout),
      .dout_oe (dout_oe)
   );
endmodule

// File: rtl/i2cps_checker.sv
module i2cps_checker
   import i2cps_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter bit          FULL_MATCH = 1'b0,
   parameter logic [31:0] BASE_ADDR  = 32'h0000_BFDC
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              rom_oe_hi,
   input logic              coarse_sel,
   input logic              scl_out,
   input logic              scl_oe,
   input logic              sda_out,
   input logic              sda_oe,
   input logic [DATA_W-1:0] dout_oe
);
   logic hit_q, a0_q, a1_q, win_now, scl_line;

   assign win_now = FULL_MATCH
      ? (bus_addr[ADDR_W-1:SEL_LSB] == BASE_ADDR[ADDR_W-1:SEL_LSB])
      : (!bus_addr[BLOCK_LO_BIT] && !bus_addr[ZERO_BIT] && bus_addr[ONE_BIT]);
   assign scl_line = scl_oe ? scl_out : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0; a0_q <= 1'b0; a1_q <= 1'b0;
      end else begin
         hit_q <= rom_oe_hi && coarse_sel && win_now;
         a0_q  <= bus_addr[SCL_SEL_BIT];
         a1_q  <= bus_addr[SDA_SEL_BIT];
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_q |=> ($stable(scl_line) && $stable(sda_oe)));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |=> (scl_line == $past(a0_q) && sda_oe == !$past(a1_q)));

   assert_rd_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe[RD_SDA_LANE] == hit_q);

   assert_lane_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe[RD_SCL_LANE] == dout_oe[RD_SDA_LANE]);

   assert_sda_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> !sda_out);

   assert_reset_R9: assert property (@(posedge clk)
      !rst_n |=> (!sda_oe && scl_line && dout_oe == '0));
endmodule

bind i2c_addr_strobe_port i2cps_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .FULL_MATCH (FULL_MATCH),
   .BASE_ADDR  (BASE_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .rom_oe_hi  (rom_oe_hi),
   .coarse_sel (coarse_sel),
   .scl_out    (scl_out),
   .scl_oe     (scl_oe),
   .sda_out    (sda_out),
   .sda_oe     (sda_oe),
   .dout_oe    (dout_oe)
);

// File: tb/i2c_addr_strobe_port_test.sv
module i2c_addr_strobe_port_test;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              rom_oe_hi = 1'b0;
   logic              coarse_sel = 1'b0;
   logic              ext_scl_low = 1'b0;
   logic              ext_sda_low = 1'b0;
   logic              scl_in, sda_in;
   logic              scl_out, scl_oe, sda_out, sda_oe;
   logic [DATA_W-1:0] dout, dout_oe;

   int total = 0;
   int bad = 0;
   logic scl_exp = 1'b1;
   logic sda_exp = 1'b1;

   always #2 clk = !clk;

   // wired-AND bus with pull-ups
   assign scl_in = (scl_oe ? scl_out : 1'b1) & !ext_scl_low;
   assign sda_in = (sda_oe ? sda_out : 1'b1) & !ext_sda_low;

   i2c_addr_strobe_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rom_oe_hi(rom_oe_hi),
      .coarse_sel(coarse_sel), .scl_in(scl_in), .sda_in(sda_in),
      .scl_out(scl_out), .scl_oe(scl_oe), .sda_out(sda_out), .sda_oe(sda_oe),
      .dout(dout), .dout_oe(dout_oe)
   );

   // {addr, strobe, sel, ext_sda_low, exp_hit, exp_scl, exp_sda}
   localparam logic [21:0] VEC [12] = '{
      {16'hBFDC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'hBFDF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      {16'hBFDD, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      {16'hBFDE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hBFDE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hFFDE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hBFFE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hBFCE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {16'hBFDE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      {16'h3FDC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {16'hBF9F, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      {16'hBFDD, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_lines(input string req);
      check((scl_oe ? scl_out : 1'b1) == scl_exp, {req, " scl"}, int'(scl_out), int'(scl_exp));
      check(sda_oe == !sda_exp, {req, " sda_oe"}, int'(sda_oe), int'(!sda_exp));
      check(sda_out == 1'b0, "R4 sda_out", int'(sda_out), 0);
      check(scl_oe == 1'b1, "R5 scl_oe", int'(scl_oe), 1);
   endtask

   // one read cycle: idle, present inputs, check readback, check update
   task automatic access(input logic [15:0] a, input logic stb, input logic sel,
                         input logic ext, input logic hit, input logic nscl,
                         input logic nsda, input string req);
      logic pin_sda, pin_scl;
      ext_sda_low = ext;
      repeat (3) @(negedge clk);
      pin_sda = sda_exp & !ext;
      pin_scl = scl_exp & !ext_scl_low;
      bus_addr = a; rom_oe_hi = stb; coarse_sel = sel;
      @(negedge clk);
      bus_addr = '0; rom_oe_hi = 1'b0; coarse_sel = 1'b0;
      check(dout_oe[0] == hit, {req, " R6 dout_oe0"}, int'(dout_oe[0]), int'(hit));
      check(dout_oe[1] == hit, {req, " R7 dout_oe1"}, int'(dout_oe[1]), int'(hit));
      check(dout_oe[DATA_W-1:2] == '0, "R7 upper enables", int'(dout_oe), 0);
      if (hit) begin
         check(dout[0] == pin_sda, {req, " R6 sda readback"}, int'(dout[0]), int'(pin_sda));
         check(dout[1] == pin_scl, {req, " R7 scl readback"}, int'(dout[1]), int'(pin_scl));
         check_lines({req, " R8 before update"});
      end
      @(negedge clk);
      scl_exp = nscl; sda_exp = nsda;
      check_lines(req);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check_lines("R9 in reset");
      check(dout_oe == '0, "R9 dout_oe", int'(dout_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_lines("R9 after reset");

      // table walk: R1 R2 R3 R6
      for (int i = 0; i < 12; i++) begin
         access(VEC[i][21:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2],
                VEC[i][1], VEC[i][0], $sformatf("R1 R2 R3 vec%0d", i));
      end
      ext_sda_low = 1'b0;

      // R7: clock stretched low by another device while latch is released
      ext_scl_low = 1'b1;
      access(16'hBFDF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R7 stretch");
      ext_scl_low = 1'b0;

      // R10: strobe held for four cycles
      repeat (3) @(negedge clk);
      bus_addr = 16'hBFDD; rom_oe_hi = 1'b1; coarse_sel = 1'b1;
      repeat (4) @(negedge clk);
      bus_addr = '0; rom_oe_hi = 1'b0; coarse_sel = 1'b0;
      @(negedge clk);
      scl_exp = 1'b1; sda_exp = 1'b0;
      check_lines("R10 held strobe");
      repeat (2) @(negedge clk);
      check_lines("R10 settle");

      // R9: reset in mid transfer releases both lines
      access(16'hBFDC, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 pre");
      rst_n = 1'b0;
      @(negedge clk);
      scl_exp = 1'b1; sda_exp = 1'b1;
      check_lines("R9 mid reset");
      rst_n = 1'b1;
      access(16'hBFDD, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 after reset");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule